// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Front End

This block is the synchronous front end of a pipelined burst static RAM. The data word is 36 bits wide and is split into four 9-bit byte lanes. On every rising clock edge it captures the address, the two chip enables, the write controls and the burst controls. It then steps a 2-bit burst counter and applies the resulting write or read to a behavioural storage array. Read data comes out of an output register, and an asynchronous output enable gates the drive flag.

An access starts in one of two ways. The first is a processor-side address strobe. It counts only while the active-low chip enable is low, it always reads, and it wins over the second strobe. The second is a controller-side address strobe. It selects or deselects the device from both chip enables and reads or writes according to the write controls. While the device is selected and neither strobe is active, each cycle continues the burst. The counter advances when the advance input is low and holds when it is high. A static order input picks linear or interleaved stepping of the two low address bits.

Top module: `sbs_front`

## Requirements
- R1: While reset is low and after it is released, the block is deselected: `dq_oe` is 0 until an access has been started.
- R2: With `adsp_n` low and `ce_n` low at a rising edge, the block captures `addr` and reads it. That word is on `dq_out` with `dq_oe` high after the next rising edge, with `oe_n` low.
- R3: When `ce_n` is high, `adsp_n` low has no effect. A burst already in progress keeps its own address sequence.
- R4: With `adsc_n` low (and the processor strobe not taking effect), the block captures `addr`. It is selected only if `ce_n` is low and `ce2` is high. When deselected, `dq_oe` stays 0 and nothing is written.
- R5: If both strobes are taken in the same cycle, the cycle is a read and nothing is written, whatever the write controls are.
- R6: With `burst_il` = 0 (linear), successive advancing beats use low address bits base+1, base+2, base+3 modulo 4, and the fifth beat returns to the base.
- R7: With `burst_il` = 1 (interleaved), successive beats use the base low bits XOR 1, 2, 3, then wrap to the base.
- R8: A continuation cycle with `adv_n` high keeps the current address. The data of the held address repeats.
- R9: `gw_n` low writes all 36 bits of `wdata`, whatever `bwe_n` and `lane_n` are.
- R10: With `gw_n` high and `bwe_n` low, each low bit `lane_n[i]` writes lane i, which is bits 9i+8 down to 9i. Other lanes keep their contents. With `bwe_n` high, or with all `lane_n` bits high, the cycle is a read.
- R11: `dq_oe` follows `oe_n` without waiting for the clock. It is 0 for the output slot that follows a write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 6 | Word address (ADDR_W) |
| ce_n | input | 1 | Active-low chip enable, also gates `adsp_n` |
| ce2 | input | 1 | Active-high chip enable |
| adsp_n | input | 1 | Processor-side address strobe, read only |
| adsc_n | input | 1 | Controller-side address strobe, read or write |
| adv_n | input | 1 | Burst advance, low steps and high waits |
| burst_il | input | 1 | Static burst order: 0 linear, 1 interleaved |
| gw_n | input | 1 | Active-low global write of all lanes |
| bwe_n | input | 1 | Active-low byte-write enable |
| lane_n | input | 4 | Active-low per-lane write strobes |
| wdata | input | 36 | Write data, sampled with the address of the cycle |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_out | output | 36 | Registered read data |
| dq_oe | output | 1 | Output drive enable (high means driven) |

## Verification
A corrupted burst counter or base register shows up within one clock at `dq_out` as a word whose low address bits break the expected linear or interleaved sequence. The bench detects this because every storage word holds a distinct pattern. A wrong select or write-classification flag shows on `dq_oe` in the output slot directly after the offending edge. A bad lane mask lies hidden until the word is read back, which is two edges after the write, and it then shows as exactly the wrong 9-bit field.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  // Low two address bits for beat number cnt of a burst that starts at base.
  function automatic logic [1:0] beat_lo(input logic il, input logic [1:0] base,
                                         input logic [1:0] cnt);
    logic [1:0] r;
    if (il) r = base ^ cnt;
    else    r = base + cnt;
    return r;
  endfunction

  // Lane mask requested by the write controls (before selection/priority).
  function automatic logic [3:0] req_lanes(input logic gw_n, input logic bwe_n,
                                           input logic [3:0] lane_n);
    logic [3:0] m;
    if (!gw_n)       m = 4'hF;
    else if (!bwe_n) m = ~lane_n;
    else             m = 4'h0;
    return m;
  endfunction

endpackage

// File: rtl/sbs_decode.sv
module sbs_decode #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce_n,
  input  logic             ce2,
  input  logic             adsp_n,
  input  logic             adsc_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             sel_q,
  output logic             load,
  output logic             load_p,
  output logic             sel_next,
  output logic             step,
  output logic [LANES-1:0] wr_mask
);
  import sbs_pkg::*;

  logic             chip_on;
  logic             load_c;
  logic [LANES-1:0] want;

  always_comb begin
    chip_on  = ~ce_n & ce2;
    load_p   = ~adsp_n & ~ce_n;
    load_c   = ~adsc_n & ~load_p;
    load     = load_p | load_c;
    sel_next = load ? chip_on : sel_q;
    step     = ~load & sel_q & ~adv_n;
    want     = LANES'(req_lanes(gw_n, bwe_n, 4'(lane_n)));
    wr_mask  = (sel_next & ~load_p) ? want : '0;
  end

  // R3
  p_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && adsc_n) |-> !load);

  // R9
  gw_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gw_n && !adsc_n && adsp_n && !ce_n && ce2) |-> (&wr_mask));

endmodule

// File: rtl/sbs_burst_addr.sv
module sbs_burst_addr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              load,
  input  logic              step,
  input  logic              il,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] next_addr
);
  import sbs_pkg::*;

  logic [1:0] base_lo;
  logic [1:0] cnt;
  logic [1:0] cnt_inc;

  always_comb begin
    cnt_inc = cnt + 2'd1;
    if (load)
      next_addr = addr_in;
    else if (step)
      next_addr = {cur_addr[ADDR_W-1:2], beat_lo(il, base_lo, cnt_inc)};
    else
      next_addr = cur_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      base_lo  <= '0;
      cnt      <= '0;
    end else begin
      cur_addr <= next_addr;
      if (load) begin
        base_lo <= addr_in[1:0];
        cnt     <= '0;
      end else if (step) begin
        cnt <= cnt_inc;
      end
    end
  end

  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(cur_addr));

  // R6
  step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cnt == $past(cnt) + 2'd1));

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cur_addr == $past(addr_in) && cnt == 2'd0));

  // R7
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2])));

endmodule

// File: rtl/sbs_lane_ram.sv
module sbs_lane_ram #(
  parameter int AW = 6,
  parameter int W  = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/sbs_front.sv
module sbs_front #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      ce_n,
  input  logic                      ce2,
  input  logic                      adsp_n,
  input  logic                      adsc_n,
  input  logic                      adv_n,
  input  logic                      burst_il,
  input  logic                      gw_n,
  input  logic                      bwe_n,
  input  logic [LANES-1:0]          lane_n,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic                      oe_n,
  output logic [LANES*LANE_W-1:0]   dq_out,
  output logic                      dq_oe
);
  localparam int DATA_W = LANES * LANE_W;

  logic              load, load_p, sel_next, step;
  logic [LANES-1:0]  wr_mask;
  logic              sel_q, acc_wr_q, rd_vld;
  logic [ADDR_W-1:0] cur_addr, next_addr;
  logic [DATA_W-1:0] rd_word, rd_reg;

  sbs_decode #(.LANES(LANES)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_n     (ce_n),
    .ce2      (ce2),
    .adsp_n   (adsp_n),
    .adsc_n   (adsc_n),
    .adv_n    (adv_n),
    .gw_n     (gw_n),
    .bwe_n    (bwe_n),
    .lane_n   (lane_n),
    .sel_q    (sel_q),
    .load     (load),
    .load_p   (load_p),
    .sel_next (sel_next),
    .step     (step),
    .wr_mask  (wr_mask)
  );

  sbs_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_in   (addr),
    .load      (load),
    .step      (step),
    .il        (burst_il),
    .cur_addr  (cur_addr),
    .next_addr (next_addr)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sbs_lane_ram #(.AW(ADDR_W), .W(LANE_W)) u_ram (
      .clk   (clk),
      .we    (wr_mask[g]),
      .waddr (next_addr),
      .wdata (wdata[g*LANE_W +: LANE_W]),
      .raddr (cur_addr),
      .rdata (rd_word[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 1'b0;
      acc_wr_q <= 1'b0;
      rd_vld   <= 1'b0;
      rd_reg   <= '0;
    end else begin
      sel_q    <= sel_next;
      acc_wr_q <= |wr_mask;
      rd_vld   <= sel_q & ~acc_wr_q;
      rd_reg   <= rd_word;
    end
  end

  assign dq_out = rd_reg;
  assign dq_oe  = ~oe_n & rd_vld;

  // R4
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adsc_n && !ce2) |=> !sel_q);

  // R5
  p_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_p && !adsc_n) |=> !acc_wr_q);

  // R11
  write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_mask) |=> ##1 !dq_oe);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_q && !load) |=> ##1 !dq_oe);

endmodule

// File: tb/sbs_front_test.sv
module sbs_front_test;
  localparam int AW = 6;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ce_n = 1'b0, ce2 = 1'b1, adsp_n = 1'b1, adsc_n = 1'b1;
  logic          adv_n = 1'b1, burst_il = 1'b0;
  logic          gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
  logic [3:0]    lane_n = 4'hF;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int total = 0;
  int bad = 0;

  sbs_front uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .ce2(ce2),
    .adsp_n(adsp_n), .adsc_n(adsc_n), .adv_n(adv_n), .burst_il(burst_il),
    .gw_n(gw_n), .bwe_n(bwe_n), .lane_n(lane_n), .wdata(wdata),
    .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #5 clk = ~clk;

  // burst table: {interleaved, base address}
  localparam logic [6:0] BURSTS [6] = '{
    {1'b0, 6'd0}, {1'b0, 6'd5}, {1'b0, 6'd14},
    {1'b1, 6'd1}, {1'b1, 6'd6}, {1'b1, 6'd35}
  };

  function automatic logic [DW-1:0] pat(input int a);
    return 36'h5A3C96E10 ^ (36'(a) * 36'h004210843);
  endfunction

  // expected address of beat i, worked out with integer arithmetic
  function automatic int beat_addr(input logic il, input int b, input int i);
    int lo;
    if (il) lo = (b % 4) ^ (i % 4);
    else    lo = ((b % 4) + i) % 4;
    return (b / 4) * 4 + lo;
  endfunction

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    adsp_n = 1'b1; adsc_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; lane_n = 4'hF;
    ce_n = 1'b0; ce2 = 1'b1;
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_data(input string req, input logic [DW-1:0] exp);
    total++;
    if (dq_oe !== 1'b1 || dq_out !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h oe=%b expected=%h oe=1", req, dq_out, dq_oe, exp);
    end
  endtask

  task automatic write_word(input int a, input logic [DW-1:0] d);
    idle();
    adsc_n = 1'b0; addr = AW'(a); gw_n = 1'b0; wdata = d;
    cyc();
    idle();
  endtask

  task automatic read_start(input int a);
    idle();
    adsp_n = 1'b0; addr = AW'(a);
    cyc();
    idle();
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] exp;
    #1;
    chk_bit("R1 in reset", dq_oe, 1'b0);
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc(); cyc();
    chk_bit("R1 after reset", dq_oe, 1'b0);

    for (int a = 0; a < 64; a++) write_word(a, pat(a));
    // deselect via controller strobe
    adsc_n = 1'b0; ce2 = 1'b0; addr = 6'd3;
    cyc(); idle(); cyc();
    chk_bit("R4 deselected", dq_oe, 1'b0);
    cyc();
    chk_bit("R4 still deselected", dq_oe, 1'b0);

    // table-driven bursts, R6 linear and R7 interleaved
    for (int t = 0; t < 6; t++) begin
      logic il;
      int b;
      il = BURSTS[t][6];
      b = int'(BURSTS[t][5:0]);
      burst_il = il;
      read_start(b);
      adv_n = 1'b0;
      for (int i = 0; i < 5; i++) begin
        cyc();
        chk_data(il ? "R7 interleaved beat" : "R6 linear beat",
                 pat(beat_addr(il, b, i)));
      end
      idle();
    end
    burst_il = 1'b0;

    // R2 single read, data one edge after load
    read_start(17);
    cyc();
    chk_data("R2 read latency", pat(17));

    // R8 wait cycles
    read_start(12);
    adv_n = 1'b0; cyc(); chk_data("R8 beat0", pat(12));
    adv_n = 1'b1; cyc(); chk_data("R8 wait a", pat(13));
    cyc(); chk_data("R8 wait b", pat(13));
    adv_n = 1'b0; cyc(); chk_data("R8 resume", pat(13));
    cyc(); chk_data("R8 next", pat(14));
    idle();

    // R3 processor strobe ignored with ce_n high
    read_start(8);
    adsp_n = 1'b0; ce_n = 1'b1; addr = 6'd40; adv_n = 1'b0;
    cyc(); chk_data("R3 first beat", pat(8));
    idle(); adv_n = 1'b0;
    cyc(); chk_data("R3 burst kept", pat(9));
    idle();

    // R5 both strobes with global write requested: read, no write
    adsp_n = 1'b0; adsc_n = 1'b0; addr = 6'd20; gw_n = 1'b0; wdata = '0;
    cyc(); idle();
    cyc(); chk_data("R5 priority read", pat(20));
    cyc(); chk_data("R5 no write", pat(20));

    // R10 each lane alone
    for (int i = 0; i < 4; i++) begin
      int a;
      a = 30 + i;
      idle();
      adsc_n = 1'b0; addr = AW'(a); bwe_n = 1'b0;
      lane_n = ~(4'b1 << i); wdata = ~pat(a);
      cyc();
      read_start(a); cyc();
      exp = pat(a);
      exp[i*9 +: 9] = ~pat(a) >> (i*9);
      chk_data("R10 single lane", exp);
    end
    // R10 bwe_n high: no write
    idle(); adsc_n = 1'b0; addr = 6'd40; lane_n = 4'h0; wdata = '0;
    cyc(); read_start(40); cyc();
    chk_data("R10 bwe_n high no write", pat(40));
    // R10 all strobes high with bwe_n low: read
    idle(); adsc_n = 1'b0; addr = 6'd42; bwe_n = 1'b0; wdata = '0;
    cyc(); read_start(42); cyc();
    chk_data("R10 no lane no write", pat(42));

    // R9 global write overrides lane controls
    idle(); adsc_n = 1'b0; addr = 6'd41; gw_n = 1'b0; bwe_n = 1'b1;
    lane_n = 4'hF; wdata = 36'h123456789;
    cyc(); read_start(41); cyc();
    chk_data("R9 override bwe_n high", 36'h123456789);
    idle(); adsc_n = 1'b0; addr = 6'd43; gw_n = 1'b0; bwe_n = 1'b0;
    lane_n = 4'b1110; wdata = 36'h0FEDCBA98;
    cyc(); read_start(43); cyc();
    chk_data("R9 override lane strobes", 36'h0FEDCBA98);

    // R11 asynchronous output enable and write-cycle high impedance
    read_start(50); cyc();
    chk_data("R11 driven", pat(50));
    #1 oe_n = 1'b1; #1;
    chk_bit("R11 oe_n high", dq_oe, 1'b0);
    oe_n = 1'b0; #1;
    chk_bit("R11 oe_n low", dq_oe, 1'b1);
    write_word(51, 36'hABCDE0123);
    cyc();
    chk_bit("R11 after write", dq_oe, 1'b0);
    cyc();
    chk_data("R11 read after write", 36'hABCDE0123);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule